// File: doc/BRIEF.md
# Inter-Processor Mailbox with Doorbells

This block gives a host processor and a security coprocessor a shared set of mailbox registers. Each side has its own register port: a word index, write data, a write strobe and read data. The host places the physical address of a request structure in the request pointer, then rings a doorbell. The coprocessor handles the request, places the finished structure's address in the reply pointer, and rings a reply doorbell back. Each doorbell raises an interrupt toward the side that has to act on it.

The doorbell word is shared, and each of its bits has one owner. The side that signals with a bit can only set it. The side that receives the bit can only clear it. Because of this, neither side can undo a bit that belongs to the other. A fourth word holds one interrupt enable for each side, and each side can change only its own enable. Both ports can read every word at any time.

The block does not interpret the structures that the pointers refer to, and it does not access memory.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-low reset, all four words read zero and both interrupts are low.
- R2: The request pointer (word index 0) takes the full 32-bit write data from a host write. A coprocessor write to index 0 leaves it unchanged.
- R3: The reply pointer (word index 2) takes the full write data from a coprocessor write. A host write to index 2 leaves it unchanged.
- R4: In the doorbell word (index 1), a host write with data bit 0 at 1 sets the request bit (bit 0). A host write with data bit 2 or bit 4 at 1 clears that reply bit.
- R5: A coprocessor write to index 1 with data bit 0 at 1 clears the request bit. Data bits 2 and 4 at 1 set the matching reply bits, so writing 0x14 sets both.
- R6: A write of 0 to any doorbell bit leaves that bit unchanged. Doorbell bits other than 0, 2 and 4 always read zero, whatever either side writes.
- R7: In the enable word (index 3), bit 0 is the host interrupt enable and only a host write changes it. Bit 1 is the coprocessor interrupt enable and only a coprocessor write changes it. All other bits read zero.
- R8: The coprocessor interrupt is high exactly while the request bit and the coprocessor enable are both set.
- R9: The host interrupt is high exactly while the host enable is set and reply bit 2 or reply bit 4 is set.
- R10: If one side sets a doorbell bit and the other side clears the same bit in the same cycle, the bit reads 0 in the next cycle. If no new clear of that bit arrives in the meantime, it reads 1 one cycle after that.
- R11: Read data is combinational from the addressed word. Both ports return the same value for the same index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_idx | input | 2 | Host word index (0 request, 1 doorbell, 2 reply, 3 enable) |
| h_wdata | input | 32 | Host write data |
| h_we | input | 1 | Host write strobe |
| h_rdata | output | 32 | Host read data |
| c_idx | input | 2 | Coprocessor word index |
| c_wdata | input | 32 | Coprocessor write data |
| c_we | input | 1 | Coprocessor write strobe |
| c_rdata | output | 32 | Coprocessor read data |
| host_irq | output | 1 | Interrupt toward the host |
| cop_irq | output | 1 | Interrupt toward the coprocessor |

## Verification
A set of a doorbell bit and a clear of that same bit can land in the same cycle. This happens when the host rings the request while the coprocessor acknowledges it, or when the coprocessor posts a reply while the host clears the previous one. The bench forces both cases by strobing both ports on the same clock edge with the same bit. It then reads the doorbell word twice in a row. The bit must be 0 on the first read and 1 on the second, and the interrupt that depends on the bit must follow it.

// File: rtl/ipc_pkg.sv
// Package ipc_pkg
// Shared word indices and bit positions for the mailbox.
// Assumes: each port addresses whole 32-bit words by a 2-bit index.
package ipc_pkg;
    localparam int IDX_W = 2;
    typedef logic [IDX_W-1:0] reg_idx_t;

    localparam reg_idx_t IDX_REQ  = 2'd0;
    localparam reg_idx_t IDX_BELL = 2'd1;
    localparam reg_idx_t IDX_RPL  = 2'd2;
    localparam reg_idx_t IDX_EN   = 2'd3;

    // Positions of the doorbell bits
    localparam int REQ_BIT   = 0;
    localparam int RPL_A_BIT = 2;
    localparam int RPL_B_BIT = 4;

    // Positions of the enable bits
    localparam int HEN_BIT = 0;
    localparam int CEN_BIT = 1;
endpackage

// File: rtl/ipc_owned_reg.sv
// Module ipc_owned_reg
// A plain register that exactly one port owns and writes.
// Assumes: the caller has already decoded the strobe for the owning port.
module ipc_owned_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on a write from the owner, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/ipc_doorbell.sv
// Module ipc_doorbell
// Shared doorbell word. Every bit is set by one port and cleared by the other.
// A clear beats a set in the same cycle, and the lost set is reapplied one
// cycle later through a pending register.
// Assumes: HOST_SET and COP_SET do not overlap. Bits in neither mask stay 0.
module ipc_doorbell #(
    parameter int           W        = 32,
    parameter logic [W-1:0] HOST_SET = '0,
    parameter logic [W-1:0] COP_SET  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         h_hit,
    input  logic [W-1:0] h_d,
    input  logic         c_hit,
    input  logic [W-1:0] c_d,
    output logic [W-1:0] bits_q
);
    logic [W-1:0] set_now, clr_now, pend_q;

    // Gather this cycle's set and clear requests from both ports
    always_comb begin
        set_now = '0;
        clr_now = '0;
        for (int i = 0; i < W; i++) begin
            if (HOST_SET[i]) begin
                set_now[i] = h_hit & h_d[i];
                clr_now[i] = c_hit & c_d[i];
            end else if (COP_SET[i]) begin
                set_now[i] = c_hit & c_d[i];
                clr_now[i] = h_hit & h_d[i];
            end
        end
    end

    // Apply sets and pending sets, let clears win, keep any set that lost
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            pend_q <= '0;
        end else begin
            bits_q <= (bits_q | set_now | pend_q) & ~clr_now;
            pend_q <= (set_now | pend_q) & clr_now;
        end
    end
endmodule

// File: rtl/ipc_read_mux.sv
// Module ipc_read_mux
// Selects the addressed word for one read port. Purely combinational.
// Assumes: all four indices are mapped.
module ipc_read_mux
    import ipc_pkg::*;
#(
    parameter int W = 32
) (
    input  reg_idx_t     idx,
    input  logic [W-1:0] req_w,
    input  logic [W-1:0] bell_w,
    input  logic [W-1:0] rpl_w,
    input  logic [W-1:0] en_w,
    output logic [W-1:0] rd
);
    // Pick a word by its index
    always_comb begin
        unique case (idx)
            IDX_REQ:  rd = req_w;
            IDX_BELL: rd = bell_w;
            IDX_RPL:  rd = rpl_w;
            default:  rd = en_w;
        endcase
    end
endmodule

// File: rtl/ipc_mailbox.sv
// Module ipc_mailbox (top)
// A two-port mailbox with a request pointer, a shared doorbell word, a reply
// pointer and an interrupt enable word, plus one interrupt toward each side.
// Assumes: both ports run on clk. Writes take effect at the next edge and
// reads are combinational.
module ipc_mailbox
    import ipc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              h_we,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [IDX_W-1:0]  c_idx,
    input  logic [DATA_W-1:0] c_wdata,
    input  logic              c_we,
    output logic [DATA_W-1:0] c_rdata,
    output logic              host_irq,
    output logic              cop_irq
);
    localparam logic [DATA_W-1:0] HOST_SET_M = DATA_W'(1) << REQ_BIT;
    localparam logic [DATA_W-1:0] COP_SET_M  =
        (DATA_W'(1) << RPL_A_BIT) | (DATA_W'(1) << RPL_B_BIT);

    logic [DATA_W-1:0] req_ptr_q, rpl_ptr_q, bell_q, en_word;
    logic              host_en_q, cop_en_q;

    ipc_owned_reg #(.W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .we(h_we && h_idx == IDX_REQ), .d(h_wdata), .q(req_ptr_q));

    ipc_owned_reg #(.W(DATA_W)) u_rpl (
        .clk(clk), .rst_n(rst_n),
        .we(c_we && c_idx == IDX_RPL), .d(c_wdata), .q(rpl_ptr_q));

    ipc_owned_reg #(.W(1)) u_hen (
        .clk(clk), .rst_n(rst_n),
        .we(h_we && h_idx == IDX_EN), .d(h_wdata[HEN_BIT]), .q(host_en_q));

    ipc_owned_reg #(.W(1)) u_cen (
        .clk(clk), .rst_n(rst_n),
        .we(c_we && c_idx == IDX_EN), .d(c_wdata[CEN_BIT]), .q(cop_en_q));

    ipc_doorbell #(.W(DATA_W), .HOST_SET(HOST_SET_M), .COP_SET(COP_SET_M)) u_bell (
        .clk(clk), .rst_n(rst_n),
        .h_hit(h_we && h_idx == IDX_BELL), .h_d(h_wdata),
        .c_hit(c_we && c_idx == IDX_BELL), .c_d(c_wdata),
        .bits_q(bell_q));

    // Pack the two enables into their readable word
    always_comb begin
        en_word          = '0;
        en_word[HEN_BIT] = host_en_q;
        en_word[CEN_BIT] = cop_en_q;
    end

    ipc_read_mux #(.W(DATA_W)) u_hrd (
        .idx(h_idx), .req_w(req_ptr_q), .bell_w(bell_q),
        .rpl_w(rpl_ptr_q), .en_w(en_word), .rd(h_rdata));

    ipc_read_mux #(.W(DATA_W)) u_crd (
        .idx(c_idx), .req_w(req_ptr_q), .bell_w(bell_q),
        .rpl_w(rpl_ptr_q), .en_w(en_word), .rd(c_rdata));

    // Raise each side's interrupt from the doorbells aimed at that side
    always_comb begin
        cop_irq  = cop_en_q & bell_q[REQ_BIT];
        host_irq = host_en_q & (bell_q[RPL_A_BIT] | bell_q[RPL_B_BIT]);
    end
endmodule

// File: rtl/ipc_mailbox_chk.sv
// Module ipc_mailbox_chk
// Temporal checks on the mailbox, attached to the top module with bind.
// Assumes: rst_n is held low from time zero until the first edge.
module ipc_mailbox_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  h_idx,
    input logic [31:0] h_wdata,
    input logic        h_we,
    input logic [1:0]  c_idx,
    input logic [31:0] c_wdata,
    input logic        c_we,
    input logic        host_irq,
    input logic        cop_irq,
    input logic [31:0] bell,
    input logic [31:0] req_ptr,
    input logic [31:0] rpl_ptr,
    input logic [31:0] en_w
);
    logic h_bell, c_bell, clash0;
    assign h_bell = h_we && h_idx == 2'd1;
    assign c_bell = c_we && c_idx == 2'd1;
    assign clash0 = h_bell && c_bell && h_wdata[0] && c_wdata[0];

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (bell == '0 && req_ptr == '0 && rpl_ptr == '0 && !host_irq && !cop_irq));

    // R2
    req_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && c_idx == 2'd0 && !(h_we && h_idx == 2'd0)) |=> $stable(req_ptr));

    // R3
    rpl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_idx == 2'd2 && !(c_we && c_idx == 2'd2)) |=> $stable(rpl_ptr));

    // R5
    reply_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_bell && c_wdata[2] && c_wdata[4] && !h_bell) |=> (bell[2] && bell[4]));

    // R6
    bell_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bell & ~32'h15) == '0);

    // R7
    cop_en_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_idx == 2'd3 && !(c_we && c_idx == 2'd3)) |=> $stable(en_w[1]));

    // R8
    cop_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq |-> (bell[0] && en_w[1]));

    // R9
    host_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (en_w[0] && (bell[2] || bell[4])));

    // R10
    clash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash0 |=> !bell[0]);

    // R10
    clash_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash0 ##1 !(c_bell && c_wdata[0]) |=> bell[0]);
endmodule

bind ipc_mailbox ipc_mailbox_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .h_idx(h_idx), .h_wdata(h_wdata), .h_we(h_we),
    .c_idx(c_idx), .c_wdata(c_wdata), .c_we(c_we),
    .host_irq(host_irq), .cop_irq(cop_irq),
    .bell(bell_q), .req_ptr(req_ptr_q), .rpl_ptr(rpl_ptr_q), .en_w(en_word));

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  h_idx = '0, c_idx = '0;
    logic [31:0] h_wdata = '0, c_wdata = '0;
    logic        h_we = 1'b0, c_we = 1'b0;
    logic [31:0] h_rdata, c_rdata;
    logic        host_irq, cop_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] h_exp;
        logic [31:0] c_exp;
        logic        hi_exp;
        logic        ci_exp;
    } item_t;
    item_t exp_q[$];

    ipc_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .h_idx(h_idx), .h_wdata(h_wdata), .h_we(h_we), .h_rdata(h_rdata),
        .c_idx(c_idx), .c_wdata(c_wdata), .c_we(c_we), .c_rdata(c_rdata),
        .host_irq(host_irq), .cop_irq(cop_irq));

    always #2.5 clk = ~clk;

    // Driver: one write from the host side
    task automatic hwr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_idx = a; h_wdata = d; c_we = 1'b0;
    endtask

    // Driver: one write from the coprocessor side
    task automatic cwr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        c_we = 1'b1; c_idx = a; c_wdata = d; h_we = 1'b0;
    endtask

    // Driver: writes from both sides on the same edge
    task automatic bwr(input logic [1:0] ha, input logic [31:0] hd,
                       input logic [1:0] ca, input logic [31:0] cd);
        @(negedge clk);
        h_we = 1'b1; h_idx = ha; h_wdata = hd;
        c_we = 1'b1; c_idx = ca; c_wdata = cd;
    endtask

    // Driver: set up a read on both ports and push the expected item
    task automatic chk(input string tag, input logic [1:0] a,
                       input logic [31:0] exp_v, input logic hi, input logic ci);
        item_t it;
        @(negedge clk);
        h_we = 1'b0; c_we = 1'b0; h_idx = a; c_idx = a;
        it.tag = tag; it.h_exp = exp_v; it.c_exp = exp_v;
        it.hi_exp = hi; it.ci_exp = ci;
        exp_q.push_back(it);
    endtask

    // Monitor: compare outputs with the queued items, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (h_rdata !== it.h_exp || c_rdata !== it.c_exp ||
                    host_irq !== it.hi_exp || cop_irq !== it.ci_exp) begin
                    errors++;
                    $display("FAIL %s: actual h=%h c=%h hirq=%b cirq=%b expected h=%h c=%h hirq=%b cirq=%b",
                             it.tag, h_rdata, c_rdata, host_irq, cop_irq,
                             it.h_exp, it.c_exp, it.hi_exp, it.ci_exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every word is zero after reset
        chk("R1 req",  2'd0, 32'h0, 1'b0, 1'b0);
        chk("R1 bell", 2'd1, 32'h0, 1'b0, 1'b0);
        chk("R1 rpl",  2'd2, 32'h0, 1'b0, 1'b0);
        chk("R1 en",   2'd3, 32'h0, 1'b0, 1'b0);
        // R2 and R11: a host write is kept, a coprocessor write is ignored
        hwr(2'd0, 32'h1000_0040);
        chk("R2 R11 req host write", 2'd0, 32'h1000_0040, 1'b0, 1'b0);
        cwr(2'd0, 32'hDEAD_BEEF);
        chk("R2 req cop ignored", 2'd0, 32'h1000_0040, 1'b0, 1'b0);
        // R3
        cwr(2'd2, 32'h1000_0040);
        hwr(2'd2, 32'h5555_5555);
        chk("R3 rpl owned by cop", 2'd2, 32'h1000_0040, 1'b0, 1'b0);
        // R7: each side changes only its own enable
        hwr(2'd3, 32'hFFFF_FFFF);
        chk("R7 host enable", 2'd3, 32'h1, 1'b0, 1'b0);
        cwr(2'd3, 32'h0);
        chk("R7 host enable kept", 2'd3, 32'h1, 1'b0, 1'b0);
        cwr(2'd3, 32'hFFFF_FFFF);
        hwr(2'd3, 32'h0);
        chk("R7 cop enable kept", 2'd3, 32'h2, 1'b0, 1'b0);
        hwr(2'd3, 32'h1);
        // R4, R8: the request doorbell raises the coprocessor interrupt
        hwr(2'd1, 32'h1);
        chk("R4 R8 request rung", 2'd1, 32'h1, 1'b0, 1'b1);
        // R6: zeros and unused bits have no effect
        hwr(2'd1, 32'hFFFF_FFEA);
        chk("R6 host unused bits", 2'd1, 32'h1, 1'b0, 1'b1);
        // R5, R9: the coprocessor acknowledges and posts the reply
        cwr(2'd1, 32'h15);
        chk("R5 R9 reply rung", 2'd1, 32'h14, 1'b1, 1'b0);
        cwr(2'd1, 32'hFFFF_FFEA);
        chk("R6 cop unused bits", 2'd1, 32'h14, 1'b1, 1'b0);
        // R4: the host clears one reply bit, and the interrupt stays
        hwr(2'd1, 32'h4);
        chk("R4 clear bit2", 2'd1, 32'h10, 1'b1, 1'b0);
        // R9: the host enable gates the interrupt
        hwr(2'd3, 32'h0);
        chk("R9 host masked", 2'd1, 32'h10, 1'b0, 1'b0);
        hwr(2'd3, 32'h1);
        hwr(2'd1, 32'h10);
        chk("R4 clear bit4", 2'd1, 32'h0, 1'b0, 1'b0);
        // R10: host sets the request while the coprocessor clears it
        bwr(2'd1, 32'h1, 2'd1, 32'h1);
        chk("R10 clear wins", 2'd1, 32'h0, 1'b0, 1'b0);
        chk("R10 set reapplied", 2'd1, 32'h1, 1'b0, 1'b1);
        // R10: coprocessor sets bit2 while the host clears it
        bwr(2'd1, 32'h4, 2'd1, 32'h4);
        chk("R10 reply clear wins", 2'd1, 32'h1, 1'b0, 1'b1);
        chk("R10 reply reapplied", 2'd1, 32'h5, 1'b1, 1'b1);
        // R8: the coprocessor enable gates its interrupt
        cwr(2'd3, 32'h0);
        chk("R8 cop masked", 2'd1, 32'h5, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule